// File: doc/BRIEF.md
# Address and Opcode Match Event Counter

This block filters a stream of memory-fabric transactions and counts the ones that meet a programmable condition. Each cycle a transaction may arrive with a valid strobe, a physical address, a 4-bit message class and a 4-bit opcode. Software loads a 64-bit match register that holds a mode selector, a reference message class, a reference opcode and a reference address.

Each valid transaction is compared against the reference fields in two ways. The address compare works at cache-line granularity. The opcode compare requires both the message class and the opcode to be equal. The mode selector then chooses how the two results combine: counting disabled, address alone, opcode alone, either, or both.

A qualifying transaction adds one to a 48-bit event counter. When the counter wraps, it sets a sticky overflow flag. Software can load the counter, and that write also clears the flag.

Top module: `txn_match_counter`

## Requirements
- R1: After reset the counter reads 0, the overflow flag is 0 and the match register is all zeros, so nothing is counted until software programs it.
- R2: Mode selector bits 63:61 equal to 000 or to any encoding other than 100, 010, 110 or 001 never count, whatever the transaction.
- R3: Mode 100 counts a valid transaction whose address matches while its opcode compare fails.
- R4: Mode 010 counts a valid transaction whose opcode compare succeeds while its address does not match. The opcode compare requires txn_class equal to register bits 47:44 and txn_opcode equal to bits 43:40. Example classes: 0000 home request, 0001 snoop response, 1110 data response.
- R5: Mode 110 counts a valid transaction when the address matches, the opcode compare succeeds, or both.
- R6: Mode 001 counts a valid transaction only when the address and the opcode compare both succeed.
- R7: The address match compares txn_addr with register bits 39:0 and ignores address bits 5:0.
- R8: The counter rises by exactly one for each qualifying transaction that has txn_valid high, and holds otherwise. A transaction with txn_valid low never counts.
- R9: A count that wraps the counter from all ones to zero sets ovf_flag. The flag then stays set until a counter write.
- R10: A counter write loads cnt_wr_data and clears ovf_flag on the next edge. The write takes precedence over a transaction that qualifies in the same cycle.
- R11: A match-register write takes effect at the next edge. A transaction in the same cycle is judged against the previous register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | 40 | Transaction physical address |
| txn_class | input | 4 | Transaction message class |
| txn_opcode | input | 4 | Transaction opcode |
| match_wr_en | input | 1 | Write strobe for the match register |
| match_wr_data | input | 64 | New match register value: mode 63:61, class 47:44, opcode 43:40, address 39:0 |
| cnt_wr_en | input | 1 | Write strobe for the counter |
| cnt_wr_data | input | 48 | New counter value |
| cnt_value | output | 48 | Current event count |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
Some rules are checked by assertions on every cycle:
- Reserved and disabled modes never produce a count.
- No count happens without txn_valid.
- The counter advances by exactly one per qualifying transaction and otherwise holds.
- The overflow flag stays set until a counter write.
- A counter write loads its data and clears the flag.
- A match-register write lands on the next edge.

The bench's scenarios are needed for the rest:
- the truth table of each combining mode;
- that address bits 5:0 are ignored while bit 6 is compared;
- the class-and-opcode equality;
- the wrap from all ones;
- same-cycle collisions between writes and transactions.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
   localparam int MATCH_W   = 64;
   localparam int MODE_HI   = 63;
   localparam int MODE_LO   = 61;
   localparam int CLASS_HI  = 47;
   localparam int CLASS_LO  = 44;
   localparam int OPC_HI    = 43;
   localparam int OPC_LO    = 40;
   localparam int REF_ADDR_W = 40;
   localparam int TAG_W     = 4;

   typedef enum logic [2:0] {
      SEL_OFF    = 3'b000,
      SEL_ADDR   = 3'b100,
      SEL_OPC    = 3'b010,
      SEL_EITHER = 3'b110,
      SEL_BOTH   = 3'b001
   } sel_e;
endpackage

// File: rtl/tmc_field_compare.sv
module tmc_field_compare #(
   parameter int ADDR_W    = 40,
   parameter int LINE_BITS = 6,
   parameter int TAG_W     = 4
) (
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic [TAG_W-1:0]  txn_class,
   input  logic [TAG_W-1:0]  txn_opcode,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [TAG_W-1:0]  ref_class,
   input  logic [TAG_W-1:0]  ref_opcode,
   output logic              addr_eq,
   output logic              opc_eq
);
   generate
      if (LINE_BITS < 0 || LINE_BITS >= ADDR_W) begin : g_bad_line
         $error("LINE_BITS must lie in [0, ADDR_W)");
      end
      if (LINE_BITS == 0) begin : g_full_cmp
         assign addr_eq = (txn_addr == ref_addr);
      end else begin : g_line_cmp
         assign addr_eq = (txn_addr[ADDR_W-1:LINE_BITS] == ref_addr[ADDR_W-1:LINE_BITS]);
      end
   endgenerate

   assign opc_eq = (txn_class == ref_class) && (txn_opcode == ref_opcode);
endmodule

// File: rtl/tmc_mode_select.sv
module tmc_mode_select
   import tmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       valid,
   input  logic       addr_eq,
   input  logic       opc_eq,
   output logic       hit
);
   logic qual;

   always_comb begin
      unique case (sel)
         SEL_ADDR:   qual = addr_eq && !opc_eq;
         SEL_OPC:    qual = opc_eq && !addr_eq;
         SEL_EITHER: qual = addr_eq || opc_eq;
         SEL_BOTH:   qual = addr_eq && opc_eq;
         default:    qual = 1'b0;
      endcase
   end

   assign hit = valid && qual;

   // R2: disabled and reserved selectors never produce a count
   p_reserved_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel inside {SEL_ADDR, SEL_OPC, SEL_EITHER, SEL_BOTH}) |-> !hit);

   // R8: no count without a valid transaction
   p_valid_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !hit);
endmodule

// File: rtl/tmc_event_counter.sv
module tmc_event_counter #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (wr_en) begin
         cnt <= wr_data;
         ovf <= 1'b0;
      end else if (inc) begin
         cnt <= cnt + ONE;
         if (cnt == ALL_ONES) ovf <= 1'b1;
      end
   end

   // R8: one step per qualifying event, hold otherwise
   p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && inc) |=> cnt == $past(cnt) + ONE);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !inc) |=> $stable(cnt));
   // R9: flag is sticky until a write
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !wr_en) |=> ovf);
   p_ovf_on_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && inc && cnt == ALL_ONES) |=> ovf && cnt == '0);
   // R10: write loads data and clears the flag
   p_write_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == $past(wr_data)) && !ovf);
endmodule

// File: rtl/txn_match_counter.sv
module txn_match_counter
   import tmc_pkg::*;
#(
   parameter int ADDR_W    = 40,
   parameter int LINE_BITS = 6,
   parameter int CNT_W     = 48
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                txn_valid,
   input  logic [ADDR_W-1:0]   txn_addr,
   input  logic [TAG_W-1:0]    txn_class,
   input  logic [TAG_W-1:0]    txn_opcode,
   input  logic                match_wr_en,
   input  logic [MATCH_W-1:0]  match_wr_data,
   input  logic                cnt_wr_en,
   input  logic [CNT_W-1:0]    cnt_wr_data,
   output logic [CNT_W-1:0]    cnt_value,
   output logic                ovf_flag
);
   generate
      if (ADDR_W > REF_ADDR_W || ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must lie in [1, REF_ADDR_W]");
      end
   endgenerate

   logic [MATCH_W-1:0] match_q;
   logic               addr_eq, opc_eq, hit;

   always_ff @(posedge clk) begin
      if (!rst_n)           match_q <= '0;
      else if (match_wr_en) match_q <= match_wr_data;
   end

   tmc_field_compare #(
      .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .TAG_W(TAG_W)
   ) u_cmp (
      .txn_addr  (txn_addr),
      .txn_class (txn_class),
      .txn_opcode(txn_opcode),
      .ref_addr  (match_q[ADDR_W-1:0]),
      .ref_class (match_q[CLASS_HI:CLASS_LO]),
      .ref_opcode(match_q[OPC_HI:OPC_LO]),
      .addr_eq   (addr_eq),
      .opc_eq    (opc_eq)
   );

   tmc_mode_select u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (match_q[MODE_HI:MODE_LO]),
      .valid  (txn_valid),
      .addr_eq(addr_eq),
      .opc_eq (opc_eq),
      .hit    (hit)
   );

   tmc_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (hit),
      .wr_en  (cnt_wr_en),
      .wr_data(cnt_wr_data),
      .cnt    (cnt_value),
      .ovf    (ovf_flag)
   );

   // R11: the match register changes only on a write, one edge later
   p_match_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      match_wr_en |=> match_q == $past(match_wr_data));
   p_match_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !match_wr_en |=> $stable(match_q));
endmodule

// File: tb/tb_txn_match_counter.sv
`timescale 1ns/1ps
module tb_txn_match_counter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        txn_valid;
   logic [39:0] txn_addr;
   logic [3:0]  txn_class, txn_opcode;
   logic        match_wr_en;
   logic [63:0] match_wr_data;
   logic        cnt_wr_en;
   logic [47:0] cnt_wr_data;
   logic [47:0] cnt_value;
   logic        ovf_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [63:0] m_match = '0;
   logic [47:0] m_cnt = '0;
   bit          m_ovf = 1'b0;

   localparam logic [39:0] LINE = 40'h12_3456_7880;

   always #4 clk = ~clk;  // 125 MHz

   txn_match_counter dut (.*);

   function automatic logic [63:0] mk(logic [2:0] sel, logic [3:0] c, logic [3:0] o, logic [39:0] a);
      return {sel, 13'd0, c, o, a};
   endfunction

   function automatic bit ref_hit(logic [63:0] m, bit v, logic [39:0] a, logic [3:0] c, logic [3:0] o);
      bit ae, oe;
      ae = (a[39:6] == m[39:6]);
      oe = (c == m[47:44]) && (o == m[43:40]);
      if (!v) return 1'b0;
      case (m[63:61])
         3'b100:  return ae && !oe;
         3'b010:  return oe && !ae;
         3'b110:  return ae || oe;
         3'b001:  return ae && oe;
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(bit v, logic [39:0] a, logic [3:0] c, logic [3:0] o,
                       bit mw = 0, logic [63:0] md = '0, bit cw = 0, logic [47:0] cd = '0);
      bit h;
      @(negedge clk);
      txn_valid = v; txn_addr = a; txn_class = c; txn_opcode = o;
      match_wr_en = mw; match_wr_data = md; cnt_wr_en = cw; cnt_wr_data = cd;
      h = ref_hit(m_match, v, a, c, o);
      if (cw) begin
         m_cnt = cd; m_ovf = 1'b0;
      end else if (h) begin
         if (m_cnt == '1) m_ovf = 1'b1;
         m_cnt = m_cnt + 48'd1;
      end
      if (mw) m_match = md;
      @(posedge clk);
      #2;
      txn_valid = 1'b0; match_wr_en = 1'b0; cnt_wr_en = 1'b0;
   endtask

   task automatic check(string tag);
      checks++;
      if (cnt_value !== m_cnt || ovf_flag !== m_ovf) begin
         failures++;
         $display("FAIL %s: cnt=%0h ovf=%0b expected cnt=%0h ovf=%0b",
                  tag, cnt_value, ovf_flag, m_cnt, m_ovf);
      end
   endtask

   task automatic prog(logic [63:0] m);
      step(1'b0, '0, '0, '0, 1'b1, m);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed_1234);
      txn_valid = 0; txn_addr = '0; txn_class = '0; txn_opcode = '0;
      match_wr_en = 0; match_wr_data = '0; cnt_wr_en = 0; cnt_wr_data = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      check("R1 reset state");
      step(1'b1, LINE, 4'h0, 4'h2);
      check("R1 cleared match register counts nothing");

      // R11: a write and a matching transaction in the same cycle use the old (disabled) settings
      step(1'b1, LINE, 4'h0, 4'h2, 1'b1, mk(3'b100, 4'h0, 4'h2, LINE));
      check("R11 same-cycle write uses old settings");
      step(1'b1, LINE | 40'h5, 4'h1, 4'h2);
      check("R3 address only, opcode differs");
      step(1'b1, LINE, 4'h0, 4'h2);
      check("R3 both match, not counted");
      step(1'b1, LINE + 40'h40, 4'h0, 4'h2);
      check("R3 opcode only, not counted");
      step(1'b1, LINE | 40'h3F, 4'h7, 4'h7);
      check("R7 low six bits ignored");
      step(1'b1, LINE ^ 40'h40, 4'h7, 4'h7);
      check("R7 bit 6 compared");
      step(1'b1, LINE ^ 40'h80_0000_0000, 4'h7, 4'h7);
      check("R7 bit 39 compared");
      step(1'b0, LINE, 4'h7, 4'h7);
      check("R8 invalid transaction ignored");

      prog(mk(3'b010, 4'hE, 4'h3, LINE));
      step(1'b1, 40'h0, 4'hE, 4'h3);
      check("R4 class and opcode match, address differs");
      step(1'b1, 40'h0, 4'h1, 4'h3);
      check("R4 class differs");
      step(1'b1, 40'h0, 4'hE, 4'h4);
      check("R4 opcode differs");
      step(1'b1, LINE, 4'hE, 4'h3);
      check("R4 both match, not counted");

      prog(mk(3'b110, 4'h1, 4'h5, LINE));
      step(1'b1, LINE, 4'h0, 4'h0);  check("R5 address only");
      step(1'b1, 40'h0, 4'h1, 4'h5); check("R5 opcode only");
      step(1'b1, LINE, 4'h1, 4'h5);  check("R5 both");
      step(1'b1, 40'h0, 4'h0, 4'h0); check("R5 neither");

      prog(mk(3'b001, 4'h0, 4'h6, LINE));
      step(1'b1, LINE, 4'h0, 4'h6);  check("R6 both match");
      step(1'b1, LINE, 4'h0, 4'h5);  check("R6 address only");
      step(1'b1, 40'h0, 4'h0, 4'h6); check("R6 opcode only");

      for (int s = 0; s < 8; s++) begin
         if (s == 3'b100 || s == 3'b010 || s == 3'b110 || s == 3'b001) continue;
         prog(mk(3'(s), 4'h0, 4'h6, LINE));
         step(1'b1, LINE, 4'h0, 4'h6);  check("R2 disabled or reserved selector, both match");
         step(1'b1, LINE, 4'h1, 4'h6);  check("R2 disabled or reserved selector, address only");
      end

      // R9 / R10 overflow path
      prog(mk(3'b110, 4'h0, 4'h1, LINE));
      step(1'b1, LINE, 4'h0, 4'h1, 1'b0, '0, 1'b1, '1);
      check("R10 counter write wins over same-cycle hit");
      step(1'b1, LINE, 4'h0, 4'h1);  check("R9 wrap sets overflow");
      step(1'b1, LINE, 4'h0, 4'h1);  check("R9 overflow sticky while counting");
      step(1'b0, LINE, 4'h0, 4'h1);  check("R9 overflow sticky while idle");
      step(1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 48'd5);
      check("R10 write loads value and clears overflow");

      // R8 constrained random
      for (int i = 0; i < 1500; i++) begin
         logic [39:0] a;
         logic [63:0] md;
         bit mw, cw;
         a = ($urandom % 2) ? (LINE | 40'($urandom % 64)) : {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
         mw = ($urandom % 40) == 0;
         cw = ($urandom % 60) == 0;
         md = mk(3'($urandom), 4'($urandom % 2), 4'($urandom % 2), LINE);
         step(1'($urandom), a, 4'($urandom % 2), 4'($urandom % 2),
              mw, md, cw, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
         check("R8 random traffic count");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule